// File: doc/BRIEF.md
# UART Register Front End

This block is the register-level face of one UART channel. The bit serializer and the baud logic are not part of it: it sits between a simple byte-wide register bus and a byte-stream line side. On the bus side it offers a pair of mode registers shared by one address, with a pointer that advances on its own. It also has a status register, a packed command register, a transmit holding register, a receive FIFO, and an interrupt status/mask pair. On the line side, received bytes come in on a valid/ready input that also carries a break flag, and transmitted bytes go out on a valid/ready output.

Software configures the channel through the mode registers and turns the transmitter and receiver on or off with command writes. It polls the status register or takes the single interrupt line, which is the OR of the interrupt status bits left unmasked. A mode-register bit chooses whether the receive interrupt follows "at least one byte waiting" or "FIFO full". A line break is stored as a zero byte. When the FIFO has no room, that zero byte replaces the newest entry, so the break is never lost.

Register offsets (byte addresses): 0x00 mode, 0x04 status (read) / ignored (write), 0x08 command (write; reads return 0), 0x0C receive data (read) / transmit holding (write), 0x10 interrupt status (read) / interrupt mask (write). Any other address reads as 0x00 and ignores writes.

Top module: `uart_regfront`

## Requirements
- R1: After reset, status reads 0x08, interrupt status reads 0x00, irq is low, both mode registers hold 0x00 and the mode pointer selects mode register 1.
- R2: A read or write at 0x00 acts on the register the pointer selects, then moves the pointer to mode register 2. The pointer stays there until a reset-pointer command.
- R3: Status bit positions: bit0 receive data ready (FIFO non-empty), bit1 FIFO full, bit2 transmitter ready, bit3 transmit holding empty, bit7 break received. Bits 4..6 read 0.
- R4: The receive FIFO holds DEPTH bytes (4 by default) and returns them oldest first. A read at 0x0C returns the oldest byte and removes it. A read at 0x0C with an empty FIFO returns 0x00 and changes nothing.
- R5: rx_ready is high only while the receiver is enabled, the FIFO is not full and rx_break is low. A byte offered while rx_ready is low is dropped.
- R6: A cycle with rx_break high sets status bit7 and interrupt bit2 and stores a 0x00 byte. If the FIFO is full and no read removes an entry in that cycle, the 0x00 replaces the newest entry and the count does not change.
- R7: Command bits [6:4]: 1 resets the mode pointer to register 1; 2 empties the FIFO and disables the receiver; 3 sets transmit-empty and disables the transmitter; 4 clears status bit7; 5 clears interrupt bit2. Other values have no effect.
- R8: Command bits [3:2] control the transmitter and bits [1:0] the receiver: 1 enables, 2 disables, 0 and 3 leave the state unchanged. The enable fields are applied after the bits [6:4] action of the same write.
- R9: A write at 0x0C loads the holding register and clears transmit-empty. tx_valid is high while the transmitter is enabled and the holding register is full. A cycle with tx_valid and tx_ready sets transmit-empty. Transmitter ready is transmitter enabled AND transmit-empty.
- R10: Interrupt status read at 0x10: bit0 equals transmitter ready. Bit1 equals FIFO full when mode register 1 bit6 is 1, and data ready otherwise. Bit2 is the sticky break-change flag. All other bits are 0.
- R11: A write at 0x10 loads the interrupt mask. irq is high exactly when interrupt status AND mask is nonzero.
- R12: Writes to 0x04 change nothing, and a read at 0x08 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read at 0x0C pops the FIFO) |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of reg_rd |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line break detected (one cycle per event) |
| rx_ready | output | 1 | Receive byte accepted this cycle when rx_valid is high |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Line side takes the byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that reg_rd and reg_wr are never high in the same cycle, so a FIFO read never coincides with a command write that would flush it. They also assume that rx_break is a pulse that is independent of rx_ready. The bench keeps to this: every bus access lasts exactly one cycle with a single strobe, and line-side stimulus is applied only between bus accesses. The bench deliberately offers bytes while the FIFO is full or the receiver is off, and asserts a break when the FIFO is full, so that the drop rule and the overwrite rule are both exercised.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
   localparam int REG_W = 8;

   localparam int OFF_MODE = 'h00;
   localparam int OFF_STAT = 'h04;
   localparam int OFF_CMD  = 'h08;
   localparam int OFF_DATA = 'h0C;
   localparam int OFF_INT  = 'h10;

   localparam int ST_RXRDY = 0;
   localparam int ST_FULL  = 1;
   localparam int ST_TXRDY = 2;
   localparam int ST_TXEMP = 3;
   localparam int ST_BRK   = 7;

   localparam int IS_TX   = 0;
   localparam int IS_RX   = 1;
   localparam int IS_DBRK = 2;

   localparam int MR1_RXSRC = 6;

   typedef enum logic [2:0] {
      MISC_NONE     = 3'd0,
      MISC_PTR_RST  = 3'd1,
      MISC_RX_RST   = 3'd2,
      MISC_TX_RST   = 3'd3,
      MISC_ERR_RST  = 3'd4,
      MISC_DBRK_CLR = 3'd5
   } misc_e;

   typedef enum logic [1:0] {
      EN_KEEP = 2'd0,
      EN_ON   = 2'd1,
      EN_OFF  = 2'd2,
      EN_RSVD = 2'd3
   } en_e;

   typedef struct packed {
      logic ptr_rst;
      logic rx_rst;
      logic tx_rst;
      logic err_rst;
      logic dbrk_clr;
      logic tx_on;
      logic tx_off;
      logic rx_on;
      logic rx_off;
   } cmd_t;
endpackage

// File: rtl/uart_rf_cmd_dec.sv
module uart_rf_cmd_dec
   import uart_rf_pkg::*;
(
   input  logic             cmd_wr,
   input  logic [REG_W-1:0] cmd_byte,
   output cmd_t             cmd
);
   misc_e misc_f;
   en_e   tx_f;
   en_e   rx_f;

   always_comb begin
      misc_f = misc_e'(cmd_byte[6:4]);
      tx_f   = en_e'(cmd_byte[3:2]);
      rx_f   = en_e'(cmd_byte[1:0]);
      cmd          = '0;
      cmd.ptr_rst  = cmd_wr && (misc_f == MISC_PTR_RST);
      cmd.rx_rst   = cmd_wr && (misc_f == MISC_RX_RST);
      cmd.tx_rst   = cmd_wr && (misc_f == MISC_TX_RST);
      cmd.err_rst  = cmd_wr && (misc_f == MISC_ERR_RST);
      cmd.dbrk_clr = cmd_wr && (misc_f == MISC_DBRK_CLR);
      cmd.tx_on    = cmd_wr && (tx_f == EN_ON);
      cmd.tx_off   = cmd_wr && (tx_f == EN_OFF);
      cmd.rx_on    = cmd_wr && (rx_f == EN_ON);
      cmd.rx_off   = cmd_wr && (rx_f == EN_OFF);
   end
endmodule

// File: rtl/uart_rf_modereg.sv
module uart_rf_modereg #(
   parameter int RW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          access,
   input  logic          wr,
   input  logic [RW-1:0] wdata,
   input  logic          ptr_rst,
   output logic [RW-1:0] rdata,
   output logic [RW-1:0] mr1,
   output logic          ptr
);
   logic [RW-1:0] mr_q [2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= 1'b0;
         mr_q[0]  <= '0;
         mr_q[1]  <= '0;
      end else begin
         if (wr)
            mr_q[ptr] <= wdata;
         if (ptr_rst)
            ptr <= 1'b0;
         else if (access)
            ptr <= 1'b1;
      end
   end

   assign rdata = mr_q[ptr];
   assign mr1   = mr_q[0];
endmodule

// File: rtl/uart_rf_rxfifo.sv
module uart_rf_rxfifo #(
   parameter int DEPTH = 4,
   parameter int DW    = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          brk,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count
);
   logic [DW-1:0] ent_q [DEPTH];
   logic [CW-1:0] cnt_ap;
   logic [CW-1:0] wr_idx;
   logic          do_pop;
   logic          do_wr;
   logic [DW-1:0] wr_val;
   logic          at_full;

   always_comb begin
      do_pop  = pop && (count != '0);
      cnt_ap  = do_pop ? count - CW'(1) : count;
      at_full = (cnt_ap == CW'(DEPTH));
      wr_idx  = at_full ? CW'(DEPTH - 1) : cnt_ap;
      do_wr   = brk || push;
      wr_val  = brk ? '0 : push_data;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [DW-1:0] shifted;
      if (g == DEPTH - 1) begin : g_last
         assign shifted = do_pop ? '0 : ent_q[g];
      end else begin : g_mid
         assign shifted = do_pop ? ent_q[g+1] : ent_q[g];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q[g] <= '0;
         else if (do_wr && (wr_idx == CW'(g)))
            ent_q[g] <= wr_val;
         else
            ent_q[g] <= shifted;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (flush)
         count <= '0;
      else if (do_wr && !at_full)
         count <= cnt_ap + CW'(1);
      else
         count <= cnt_ap;
   end

   assign head = (count != '0) ? ent_q[0] : '0;
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_rf_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DEPTH  = 4,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_break,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_ready,
   output logic              irq
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_regfront: DEPTH must be at least 2");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("uart_regfront: ADDR_W must cover offset 0x10");
   end

   logic sel_mode, sel_stat, sel_cmd, sel_data, sel_int;
   cmd_t cmd;
   logic [REG_W-1:0] mode_rdata, mr1_val;
   logic             mode_ptr;
   logic [REG_W-1:0] rx_head;
   logic [CW-1:0]    rx_cnt;
   logic             tx_en_q, rx_en_q, txemp_q, brk_st_q, dbrk_q;
   logic [REG_W-1:0] thr_q, imr_q;
   logic             rxrdy, full, txrdy, rx_int;
   logic [REG_W-1:0] stat_byte, isr_byte;
   logic             thr_wr, tx_fire;

   always_comb begin
      sel_mode = (reg_addr == ADDR_W'(OFF_MODE));
      sel_stat = (reg_addr == ADDR_W'(OFF_STAT));
      sel_cmd  = (reg_addr == ADDR_W'(OFF_CMD));
      sel_data = (reg_addr == ADDR_W'(OFF_DATA));
      sel_int  = (reg_addr == ADDR_W'(OFF_INT));
   end

   uart_rf_cmd_dec u_cmd (
      .cmd_wr   (reg_wr && sel_cmd),
      .cmd_byte (reg_wdata),
      .cmd      (cmd)
   );

   uart_rf_modereg #(.RW(REG_W)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .access  ((reg_wr || reg_rd) && sel_mode),
      .wr      (reg_wr && sel_mode),
      .wdata   (reg_wdata),
      .ptr_rst (cmd.ptr_rst),
      .rdata   (mode_rdata),
      .mr1     (mr1_val),
      .ptr     (mode_ptr)
   );

   assign full     = (rx_cnt == CW'(DEPTH));
   assign rxrdy    = (rx_cnt != '0);
   assign rx_ready = rx_en_q && !full && !rx_break;

   uart_rf_rxfifo #(.DEPTH(DEPTH), .DW(REG_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (cmd.rx_rst),
      .push      (rx_valid && rx_ready),
      .push_data (rx_data),
      .brk       (rx_break),
      .pop       (reg_rd && sel_data),
      .head      (rx_head),
      .count     (rx_cnt)
   );

   assign thr_wr   = reg_wr && sel_data;
   assign tx_valid = tx_en_q && !txemp_q;
   assign tx_data  = thr_q;
   assign tx_fire  = tx_valid && tx_ready;
   assign txrdy    = tx_en_q && txemp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en_q  <= 1'b0;
         rx_en_q  <= 1'b0;
         txemp_q  <= 1'b1;
         thr_q    <= '0;
         brk_st_q <= 1'b0;
         dbrk_q   <= 1'b0;
         imr_q    <= '0;
      end else begin
         if (cmd.tx_on)
            tx_en_q <= 1'b1;
         else if (cmd.tx_off || cmd.tx_rst)
            tx_en_q <= 1'b0;

         if (cmd.rx_on)
            rx_en_q <= 1'b1;
         else if (cmd.rx_off || cmd.rx_rst)
            rx_en_q <= 1'b0;

         if (thr_wr) begin
            thr_q   <= reg_wdata;
            txemp_q <= 1'b0;
         end else if (cmd.tx_rst || tx_fire) begin
            txemp_q <= 1'b1;
         end

         if (rx_break)
            brk_st_q <= 1'b1;
         else if (cmd.err_rst)
            brk_st_q <= 1'b0;

         if (rx_break)
            dbrk_q <= 1'b1;
         else if (cmd.dbrk_clr)
            dbrk_q <= 1'b0;

         if (reg_wr && sel_int)
            imr_q <= reg_wdata;
      end
   end

   assign rx_int = mr1_val[MR1_RXSRC] ? full : rxrdy;

   always_comb begin
      stat_byte           = '0;
      stat_byte[ST_RXRDY] = rxrdy;
      stat_byte[ST_FULL]  = full;
      stat_byte[ST_TXRDY] = txrdy;
      stat_byte[ST_TXEMP] = txemp_q;
      stat_byte[ST_BRK]   = brk_st_q;
      isr_byte            = '0;
      isr_byte[IS_TX]     = txrdy;
      isr_byte[IS_RX]     = rx_int;
      isr_byte[IS_DBRK]   = dbrk_q;
   end

   assign irq = |(isr_byte & imr_q);

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         if (sel_mode)      reg_rdata = mode_rdata;
         else if (sel_stat) reg_rdata = stat_byte;
         else if (sel_data) reg_rdata = rx_head;
         else if (sel_int)  reg_rdata = isr_byte;
      end
   end
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
   import uart_rf_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DEPTH  = 4,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_wdata,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              rx_break,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              irq,
   input logic [CW-1:0]     fifo_cnt,
   input logic              mode_ptr,
   input logic [7:0]        stat,
   input logic [7:0]        isr,
   input logic [7:0]        imr
);
   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CW'(DEPTH));

   assert_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_wr && reg_addr == ADDR_W'(OFF_DATA) && fifo_cnt != '0
       && !rx_break && !(rx_valid && rx_ready))
      |=> fifo_cnt == $past(fifo_cnt) - CW'(1));

   assert_no_accept_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> !stat[ST_FULL]);

   assert_break_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_break && !(reg_wr && reg_addr == ADDR_W'(OFF_CMD)))
      |=> isr[IS_DBRK] && stat[ST_BRK] && stat[ST_RXRDY]);

   assert_ptr_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFF_CMD) && reg_wdata[6:4] == 3'd1)
      |=> !mode_ptr);

   assert_send_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && !(reg_wr && reg_addr == ADDR_W'(OFF_DATA)))
      |=> stat[ST_TXEMP]);

   assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !stat[ST_TXRDY]);

   assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (imr != 8'h00) && (isr != 8'h00));
endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .rx_break  (rx_break),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .irq       (irq),
   .fifo_cnt  (rx_cnt),
   .mode_ptr  (mode_ptr),
   .stat      (stat_byte),
   .isr       (isr_byte),
   .imr       (imr_q)
);

// File: tb/sim_uart_regfront.sv
`timescale 1ns/1ps
module sim_uart_regfront;
   localparam int AW = 5;
   localparam logic [4:0] A_MODE = 5'h00, A_STAT = 5'h04, A_CMD = 5'h08,
                          A_DATA = 5'h0C, A_INT = 5'h10;
   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_RX = 2'd2, OP_IRQ = 2'd3;
   localparam int NV = 28;
   // entry: {op, addr, data, expected, requirement number}
   localparam logic [26:0] VEC [NV] = '{
      {OP_RD,  A_STAT, 8'h00, 8'h08, 4'd1},  // R1 status after reset
      {OP_RD,  A_INT,  8'h00, 8'h00, 4'd1},  // R1
      {OP_IRQ, A_STAT, 8'h00, 8'h00, 4'd1},  // R1
      {OP_WR,  A_CMD,  8'h05, 8'h00, 4'd8},  // R8 enable tx and rx
      {OP_RD,  A_STAT, 8'h00, 8'h0C, 4'd8},  // R8
      {OP_WR,  A_MODE, 8'h40, 8'h00, 4'd2},  // R2 mode 1
      {OP_WR,  A_MODE, 8'h17, 8'h00, 4'd2},  // R2 mode 2
      {OP_RD,  A_MODE, 8'h00, 8'h17, 4'd2},  // R2 pointer stays on 2
      {OP_WR,  A_CMD,  8'h10, 8'h00, 4'd7},  // R7 reset pointer
      {OP_RD,  A_MODE, 8'h00, 8'h40, 4'd2},  // R2
      {OP_RD,  A_MODE, 8'h00, 8'h17, 4'd2},  // R2
      {OP_WR,  A_INT,  8'h02, 8'h00, 4'd11}, // R11 mask receive
      {OP_RX,  A_STAT, 8'h11, 8'h00, 4'd4},
      {OP_RX,  A_STAT, 8'h22, 8'h00, 4'd4},
      {OP_RX,  A_STAT, 8'h33, 8'h00, 4'd4},
      {OP_RD,  A_STAT, 8'h00, 8'h0D, 4'd3},  // R3
      {OP_RD,  A_INT,  8'h00, 8'h01, 4'd10}, // R10 rx follows full
      {OP_IRQ, A_STAT, 8'h00, 8'h00, 4'd11}, // R11
      {OP_RX,  A_STAT, 8'h44, 8'h00, 4'd4},
      {OP_RD,  A_STAT, 8'h00, 8'h0F, 4'd3},  // R3 full
      {OP_RD,  A_INT,  8'h00, 8'h03, 4'd10}, // R10
      {OP_IRQ, A_STAT, 8'h00, 8'h01, 4'd11}, // R11
      {OP_RD,  A_DATA, 8'h00, 8'h11, 4'd4},  // R4 oldest first
      {OP_RD,  A_STAT, 8'h00, 8'h0D, 4'd4},  // R4
      {OP_IRQ, A_STAT, 8'h00, 8'h00, 4'd11}, // R11
      {OP_WR,  A_STAT, 8'hFF, 8'h00, 4'd12}, // R12 ignored write
      {OP_RD,  A_STAT, 8'h00, 8'h0D, 4'd12}, // R12
      {OP_RD,  A_CMD,  8'h00, 8'h00, 4'd12}  // R12
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 0, reg_rd = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic rx_valid = 0, rx_break = 0, rx_ready;
   logic [7:0] rx_data = '0;
   logic tx_valid, tx_ready = 0, irq;
   logic [7:0] tx_data;
   int total = 0, bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   uart_regfront #(.ADDR_W(AW), .DEPTH(4)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
      .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
      logic [7:0] v;
      bus_rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic rx_push(input logic [7:0] d);
      @(negedge clk);
      rx_valid = 1; rx_data = d;
      @(negedge clk);
      rx_valid = 0;
   endtask

   task automatic brk_pulse();
      @(negedge clk);
      rx_break = 1;
      @(negedge clk);
      rx_break = 0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         logic [4:0] a;
         logic [7:0] d, e, v;
         string tag;
         {op, a, d, e} = VEC[i][26:4];
         tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
         case (op)
            OP_WR:  bus_wr(a, d);
            OP_RD:  begin bus_rd(a, v); chk(tag, v, e); end
            OP_RX:  rx_push(d);
            default: begin @(negedge clk); chk(tag, {7'd0, irq}, e); end
         endcase
      end

      // FIFO now 22,33,44; fill to full, offer a byte that must be dropped
      rx_push(8'h55);
      @(negedge clk);
      chk("R5 ready low when full", {7'd0, rx_ready}, 8'h00);
      rx_push(8'h66);
      brk_pulse();
      rd_chk("R6 break status", A_STAT, 8'h8F);
      rd_chk("R10 isr with break", A_INT, 8'h07);
      rd_chk("R4 pop 1", A_DATA, 8'h22);
      rd_chk("R4 pop 2", A_DATA, 8'h33);
      rd_chk("R4 pop 3", A_DATA, 8'h44);
      rd_chk("R6 overwrite newest", A_DATA, 8'h00);
      rd_chk("R4 empty read", A_DATA, 8'h00);
      rd_chk("R4 empty status", A_STAT, 8'h8C);

      bus_wr(A_CMD, 8'h40);
      rd_chk("R7 error reset", A_STAT, 8'h0C);
      bus_wr(A_CMD, 8'h50);
      rd_chk("R7 delta break clear", A_INT, 8'h01);

      brk_pulse();
      rd_chk("R6 break not full", A_STAT, 8'h8D);
      rd_chk("R6 zero byte", A_DATA, 8'h00);
      bus_wr(A_CMD, 8'h40);
      bus_wr(A_CMD, 8'h50);

      // receive interrupt follows data-ready when mode 1 bit6 is 0
      bus_wr(A_CMD, 8'h10);
      bus_wr(A_MODE, 8'h00);
      rx_push(8'h5A);
      rd_chk("R10 rx follows ready", A_INT, 8'h03);
      @(negedge clk);
      chk("R11 irq on ready", {7'd0, irq}, 8'h01);
      rd_chk("R4 single byte", A_DATA, 8'h5A);

      // transmit path
      bus_wr(A_DATA, 8'hA5);
      rd_chk("R9 holding full", A_STAT, 8'h00);
      chk("R9 tx_valid", {7'd0, tx_valid}, 8'h01);
      chk("R9 tx_data", tx_data, 8'hA5);
      @(negedge clk);
      tx_ready = 1;
      @(negedge clk);
      tx_ready = 0;
      chk("R9 tx_valid drop", {7'd0, tx_valid}, 8'h00);
      rd_chk("R9 sent", A_STAT, 8'h0C);

      bus_wr(A_CMD, 8'h08);
      rd_chk("R8 tx disabled", A_STAT, 8'h08);
      bus_wr(A_DATA, 8'h3C);
      chk("R8 no send while off", {7'd0, tx_valid}, 8'h00);
      rd_chk("R9 holding while off", A_STAT, 8'h00);
      bus_wr(A_CMD, 8'h30);
      rd_chk("R7 tx reset", A_STAT, 8'h08);
      bus_wr(A_CMD, 8'h04);
      rd_chk("R8 tx re-enable", A_STAT, 8'h0C);
      bus_wr(A_CMD, 8'h0C);
      rd_chk("R8 reserved keeps", A_STAT, 8'h0C);

      // receiver reset
      rx_push(8'h77);
      rd_chk("R3 one byte", A_STAT, 8'h0D);
      bus_wr(A_CMD, 8'h20);
      rd_chk("R7 rx reset", A_STAT, 8'h0C);
      chk("R7 rx disabled", {7'd0, rx_ready}, 8'h00);
      rx_push(8'h88);
      rd_chk("R5 dropped when off", A_STAT, 8'h0C);
      bus_wr(A_CMD, 8'h01);
      @(negedge clk);
      chk("R8 rx enable", {7'd0, rx_ready}, 8'h01);

      bus_wr(A_INT, 8'h01);
      @(negedge clk);
      chk("R11 tx mask irq", {7'd0, irq}, 8'h01);
      bus_wr(A_INT, 8'h00);
      @(negedge clk);
      chk("R11 all masked", {7'd0, irq}, 8'h00);

      // reset during operation
      bus_wr(A_MODE, 8'h99);
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      rd_chk("R1 status after reset", A_STAT, 8'h08);
      rd_chk("R1 mode 1 cleared", A_MODE, 8'h00);
      rd_chk("R1 mode 2 cleared", A_MODE, 8'h00);
      chk("R1 irq low", {7'd0, irq}, 8'h00);

      finish_run();
   end
endmodule